// File: doc/BRIEF.md
# Multi-Increment Link Event Counter Bank

This block is a bank of programmable event counters that watches a serial link layer moving up to two flits per cycle in each direction. Every counter has its own control word. The control word picks an event code, a direction (receive or transmit) and whether the counter runs. On each clock an enabled counter adds its event's increment for that cycle, which is 0, 1 or 2. A shared mask/match pair can also turn outgoing packet headers into a one-per-packet event.

Software reaches everything through one flat register port with a combinational read path. That port lets it program controls, preload or zero counters, set the packet qualifier and clear the sticky overflow flags. Each counter is 48 bits wide and wraps modulo 2^48. When an addition carries out of the top bit, the counter's overflow flag is raised and stays up until software clears it.

Top module: `flit_evt_counter_bank`

## Requirements
- R1: After reset, every counter, control word, mask, match and overflow flag reads zero.
- R2: Register map (four counters): addresses 0-3 are control words, 4-7 counter values, 8 the mask, 9 the match, 10 the overflow flags (bit i for counter i). Control word bits: [7:0] event code, [8] direction (0 = receive, 1 = transmit), [9] enable, [10] counter reset. Control, mask and match read back as written, and the reset bit reads 0.
- R3: Event code 0x10+k (k below the flit event count) adds flit event k's 2-bit per-cycle increment (0, 1 or 2) to an enabled counter.
- R4: A flit-coded counter adds only the increment of the direction its direction bit selects. The other direction has no effect.
- R5: Event code 0x32 adds 1 for each cycle the regulator-hot input is high, on any counter, whatever its direction bit.
- R6: Event code 0x20 adds 1 for each valid transmit packet whose header satisfies (header AND mask) == (match AND mask), where header bits [7:4] are message class and [3:0] are opcode. With the direction bit at 0 it adds nothing.
- R7: Any event code not listed in R3, R5 or R6 adds nothing.
- R8: A disabled counter holds its value while events arrive.
- R9: A software write to a counter value takes effect on the next edge, and any increment in that same cycle is dropped.
- R10: Writing a control word with bit 10 set clears that counter to zero on the next edge, with any increment in that cycle dropped.
- R11: A counter wraps modulo 2^48, and an addition that carries out of bit 47 sets that counter's overflow flag.
- R12: Overflow flags are sticky. Writing 1 to a flag bit at address 10 clears it, unless a carry sets it in the same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | CTR_W | Register write data |
| reg_rdata | output | CTR_W | Combinational read data for reg_addr |
| flit_rx_inc | input | 2*NUM_FLIT | Per-cycle receive flit increments, 2 bits per event |
| flit_tx_inc | input | 2*NUM_FLIT | Per-cycle transmit flit increments, 2 bits per event |
| vr_hot | input | 1 | Regulator-hot condition, counted per cycle |
| tx_pkt_valid | input | 1 | Outgoing packet header is valid this cycle |
| tx_pkt_hdr | input | HDR_W | Outgoing header: message class [7:4], opcode [3:0] |
| ovf_flag | output | NUM_CTR | Sticky overflow flags, one per counter |

## Verification
Two pairs of actions can land on the same edge: a software write to a counter value together with that counter's increment, and a carry that sets an overflow flag together with a software write that clears it. The bench provokes the first by preloading a counter that counts the always-high regulator-hot input. It provokes the second by preloading that counter two below the wrap point and placing the clear write on the very edge of the carry. A behavioural model tracks every counter and flag on every clock. Reads of the counter and of the flag register are compared with the model and with the values worked out by hand: the write value wins, and the flag stays set.

// File: rtl/fecb_pkg.sv
package fecb_pkg;

  localparam logic [7:0] CODE_FLIT_BASE = 8'h10;
  localparam logic [7:0] CODE_PKT_MATCH = 8'h20;
  localparam logic [7:0] CODE_VR_HOT    = 8'h32;

  localparam int DIR_BIT = 8;
  localparam int EN_BIT  = 9;
  localparam int RST_BIT = 10;

  typedef struct packed {
    logic       en;
    logic       dir;
    logic [7:0] sel;
  } ctl_t;

  function automatic logic hdr_hit(input logic [15:0] hdr,
                                   input logic [15:0] mask,
                                   input logic [15:0] match);
    return ((hdr ^ match) & mask) == '0;
  endfunction

endpackage

// File: rtl/fecb_pkt_match.sv
module fecb_pkt_match #(
  parameter int HDR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             match_we,
  input  logic [HDR_W-1:0] wdata,
  input  logic             pkt_valid,
  input  logic [HDR_W-1:0] pkt_hdr,
  output logic [HDR_W-1:0] mask_q,
  output logic [HDR_W-1:0] match_q,
  output logic             hit
);
  import fecb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      match_q <= '0;
    end else begin
      if (mask_we)  mask_q  <= wdata;
      if (match_we) match_q <= wdata;
    end
  end

  assign hit = pkt_valid && hdr_hit(16'(pkt_hdr), 16'(mask_q), 16'(match_q));

endmodule

// File: rtl/fecb_evt_mux.sv
module fecb_evt_mux #(
  parameter int NUM_FLIT = 4
) (
  input  fecb_pkg::ctl_t            ctl,
  input  logic [2*NUM_FLIT-1:0]     flit_rx,
  input  logic [2*NUM_FLIT-1:0]     flit_tx,
  input  logic                      vr_hot,
  input  logic                      pkt_hit,
  output logic [1:0]                inc
);
  import fecb_pkg::*;

  int idx;

  always_comb begin
    inc = 2'd0;
    idx = int'(ctl.sel) - int'(CODE_FLIT_BASE);
    if (idx >= 0 && idx < NUM_FLIT) begin
      inc = ctl.dir ? flit_tx[idx*2 +: 2] : flit_rx[idx*2 +: 2];
    end else if (ctl.sel == CODE_VR_HOT) begin
      inc = {1'b0, vr_hot};
    end else if (ctl.sel == CODE_PKT_MATCH) begin
      inc = {1'b0, ctl.dir & pkt_hit};
    end
  end

endmodule

// File: rtl/fecb_counter.sv
module fecb_counter #(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       inc,
  input  logic             sw_wr,
  input  logic [CTR_W-1:0] sw_data,
  input  logic             sw_clr,
  input  logic             ovf_clr,
  output logic [CTR_W-1:0] value,
  output logic             ovf,
  output logic             wrap
);

  function automatic logic [CTR_W:0] add_inc(input logic [CTR_W-1:0] v,
                                             input logic [1:0] d);
    return {1'b0, v} + {{(CTR_W-1){1'b0}}, d};
  endfunction

  logic [CTR_W:0] sum;
  logic           bump;

  assign sum  = add_inc(value, inc);
  assign bump = en && !sw_wr && !sw_clr;
  assign wrap = bump && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      ovf   <= 1'b0;
    end else begin
      if (sw_clr)     value <= '0;
      else if (sw_wr) value <= sw_data;
      else if (bump)  value <= sum[CTR_W-1:0];
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/flit_evt_counter_bank.sv
module flit_evt_counter_bank #(
  parameter int NUM_CTR  = 4,
  parameter int CTR_W    = 48,
  parameter int NUM_FLIT = 4,
  parameter int HDR_W    = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [CTR_W-1:0]      reg_wdata,
  output logic [CTR_W-1:0]      reg_rdata,
  input  logic [2*NUM_FLIT-1:0] flit_rx_inc,
  input  logic [2*NUM_FLIT-1:0] flit_tx_inc,
  input  logic                  vr_hot,
  input  logic                  tx_pkt_valid,
  input  logic [HDR_W-1:0]      tx_pkt_hdr,
  output logic [NUM_CTR-1:0]    ovf_flag
);
  import fecb_pkg::*;

  localparam int CNT_BASE   = NUM_CTR;
  localparam int MASK_ADDR  = 2 * NUM_CTR;
  localparam int MATCH_ADDR = 2 * NUM_CTR + 1;
  localparam int OVF_ADDR   = 2 * NUM_CTR + 2;
  localparam int CTL_W      = $bits(ctl_t);

  // named internal events, observed by the bound checker
  ctl_t                          ctl_q   [NUM_CTR];
  logic [NUM_CTR-1:0]            ctl_wr;
  logic [NUM_CTR-1:0]            ctl_en;
  logic [NUM_CTR-1:0]            cnt_wr;
  logic [NUM_CTR-1:0]            cnt_rst;
  logic [NUM_CTR-1:0]            ovf_clr;
  logic [NUM_CTR-1:0]            ctr_wrap;
  logic [NUM_CTR-1:0][1:0]       ctr_inc;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val;

  logic [HDR_W-1:0] mask_q, match_q;
  logic             pkt_hit;
  logic             ovf_wr;

  assign ovf_wr = reg_we && (reg_addr == ADDR_W'(OVF_ADDR));

  fecb_pkt_match #(.HDR_W(HDR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (reg_we && (reg_addr == ADDR_W'(MASK_ADDR))),
    .match_we  (reg_we && (reg_addr == ADDR_W'(MATCH_ADDR))),
    .wdata     (reg_wdata[HDR_W-1:0]),
    .pkt_valid (tx_pkt_valid),
    .pkt_hdr   (tx_pkt_hdr),
    .mask_q    (mask_q),
    .match_q   (match_q),
    .hit       (pkt_hit)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctl_wr[i]  = reg_we && (reg_addr == ADDR_W'(i));
    assign cnt_wr[i]  = reg_we && (reg_addr == ADDR_W'(CNT_BASE + i));
    assign cnt_rst[i] = ctl_wr[i] && reg_wdata[RST_BIT];
    assign ovf_clr[i] = ovf_wr && reg_wdata[i];
    assign ctl_en[i]  = ctl_q[i].en;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[i] <= '0;
      end else if (ctl_wr[i]) begin
        ctl_q[i].sel <= reg_wdata[7:0];
        ctl_q[i].dir <= reg_wdata[DIR_BIT];
        ctl_q[i].en  <= reg_wdata[EN_BIT];
      end
    end

    fecb_evt_mux #(.NUM_FLIT(NUM_FLIT)) u_mux (
      .ctl     (ctl_q[i]),
      .flit_rx (flit_rx_inc),
      .flit_tx (flit_tx_inc),
      .vr_hot  (vr_hot),
      .pkt_hit (pkt_hit),
      .inc     (ctr_inc[i])
    );

    fecb_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl_en[i]),
      .inc     (ctr_inc[i]),
      .sw_wr   (cnt_wr[i]),
      .sw_data (reg_wdata),
      .sw_clr  (cnt_rst[i]),
      .ovf_clr (ovf_clr[i]),
      .value   (ctr_val[i]),
      .ovf     (ovf_flag[i]),
      .wrap    (ctr_wrap[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(i))            reg_rdata = CTR_W'(CTL_W'(ctl_q[i]));
      if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata = ctr_val[i];
    end
    if (reg_addr == ADDR_W'(MASK_ADDR))  reg_rdata = CTR_W'(mask_q);
    if (reg_addr == ADDR_W'(MATCH_ADDR)) reg_rdata = CTR_W'(match_q);
    if (reg_addr == ADDR_W'(OVF_ADDR))   reg_rdata = CTR_W'(ovf_flag);
  end

endmodule

// File: rtl/fecb_checker.sv
module fecb_checker #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CTR_W-1:0]              reg_wdata,
  input logic [NUM_CTR-1:0]            ctl_en,
  input logic [NUM_CTR-1:0]            cnt_wr,
  input logic [NUM_CTR-1:0]            cnt_rst,
  input logic [NUM_CTR-1:0]            ovf_clr,
  input logic [NUM_CTR-1:0]            ctr_wrap,
  input logic [NUM_CTR-1:0][1:0]       ctr_inc,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val,
  input logic [NUM_CTR-1:0]            ovf_flag
);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    assert_adds_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en[i] && !cnt_wr[i] && !cnt_rst[i]) |=>
        ctr_val[i] == CTR_W'($past(ctr_val[i]) + CTR_W'($past(ctr_inc[i]))));

    assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en[i] && !cnt_wr[i] && !cnt_rst[i]) |=> $stable(ctr_val[i]));

    assert_sw_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[i] |=> ctr_val[i] == $past(reg_wdata));

    assert_rst_bit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst[i] |=> ctr_val[i] == '0);

    assert_wrap_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wrap[i] |=> (ovf_flag[i] && ctr_val[i] < CTR_W'(2)));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[i] && !ovf_clr[i]) |=> ovf_flag[i]);
  end

endmodule

bind flit_evt_counter_bank fecb_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .ctl_en    (ctl_en),
  .cnt_wr    (cnt_wr),
  .cnt_rst   (cnt_rst),
  .ovf_clr   (ovf_clr),
  .ctr_wrap  (ctr_wrap),
  .ctr_inc   (ctr_inc),
  .ctr_val   (ctr_val),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_flit_evt_counter_bank.sv
module sim_flit_evt_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 48;
  localparam int NF = 4;
  localparam int HW = 8;
  localparam int AW = 4;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [2*NF-1:0] flit_rx_inc, flit_tx_inc;
  logic vr_hot = 1'b0;
  logic tx_pkt_valid = 1'b0;
  logic [HW-1:0] tx_pkt_hdr = '0;
  logic [NC-1:0] ovf_flag;

  int rx_v[NF];
  int tx_v[NF];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit traffic = 0;
  bit live = 0;

  // behavioural reference state
  logic [CW-1:0] m_ctr[NC];
  logic [7:0]    m_sel[NC];
  bit            m_dir[NC];
  bit            m_en[NC];
  logic [HW-1:0] m_mask, m_match;
  bit            m_ovf[NC];

  flit_evt_counter_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flit_rx_inc(flit_rx_inc), .flit_tx_inc(flit_tx_inc), .vr_hot(vr_hot),
    .tx_pkt_valid(tx_pkt_valid), .tx_pkt_hdr(tx_pkt_hdr), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NF; k++) begin
      flit_rx_inc[k*2 +: 2] = 2'(rx_v[k]);
      flit_tx_inc[k*2 +: 2] = 2'(tx_v[k]);
    end
  end

  function automatic int m_inc(int i);
    int code;
    code = int'(m_sel[i]);
    if (code >= 16 && code < 16 + NF) return m_dir[i] ? tx_v[code-16] : rx_v[code-16];
    if (code == 50) return vr_hot ? 1 : 0;
    if (code == 32)
      return (m_dir[i] && tx_pkt_valid && ((tx_pkt_hdr & m_mask) == (m_match & m_mask))) ? 1 : 0;
    return 0;
  endfunction

  function automatic logic [CW-1:0] m_read(int a);
    logic [CW-1:0] f;
    f = '0;
    if (a < NC) return CW'({m_en[a], m_dir[a], m_sel[a]});
    if (a < 2*NC) return m_ctr[a-NC];
    if (a == 2*NC) return CW'(m_mask);
    if (a == 2*NC+1) return CW'(m_match);
    if (a == 2*NC+2) begin
      for (int i = 0; i < NC; i++) f[i] = m_ovf[i];
      return f;
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    int inc[NC];
    bit setf[NC];
    logic [CW:0] s;
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_ctr[i] = '0; m_sel[i] = '0; m_dir[i] = 0; m_en[i] = 0; m_ovf[i] = 0;
      end
      m_mask = '0; m_match = '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        inc[i] = m_inc(i);
        setf[i] = 0;
      end
      for (int i = 0; i < NC; i++) begin
        if (reg_we && int'(reg_addr) == i && reg_wdata[10]) m_ctr[i] = '0;
        else if (reg_we && int'(reg_addr) == NC + i) m_ctr[i] = reg_wdata;
        else if (m_en[i]) begin
          s = {1'b0, m_ctr[i]} + (CW+1)'(inc[i]);
          setf[i] = s[CW];
          m_ctr[i] = s[CW-1:0];
        end
        if (reg_we && int'(reg_addr) == i) begin
          m_sel[i] = reg_wdata[7:0]; m_dir[i] = reg_wdata[8]; m_en[i] = reg_wdata[9];
        end
        if (reg_we && int'(reg_addr) == 2*NC+2 && reg_wdata[i]) m_ovf[i] = 0;
        if (setf[i]) m_ovf[i] = 1;
      end
      if (reg_we && int'(reg_addr) == 2*NC) m_mask = reg_wdata[HW-1:0];
      if (reg_we && int'(reg_addr) == 2*NC+1) m_match = reg_wdata[HW-1:0];
    end
  end

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // flags compared with the model on every clock
  always @(negedge clk) begin
    logic [CW-1:0] f;
    if (live) begin
      f = m_read(2*NC+2);
      chk("R11 flags per cycle", CW'(ovf_flag), f);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (traffic) begin
      for (int k = 0; k < NF; k++) begin
        rx_v[k] = $urandom_range(0, 2);
        tx_v[k] = $urandom_range(0, 2);
      end
      vr_hot = 1'($urandom_range(0, 1));
      tx_pkt_valid = 1'($urandom_range(0, 1));
      tx_pkt_hdr = HW'($urandom_range(0, 255));
    end
  end

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk(tag, reg_rdata, m_read(a));
  endtask

  task automatic rd_abs(input int a, input logic [CW-1:0] exp, input string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic quiet();
    traffic = 0;
    @(negedge clk);
    for (int k = 0; k < NF; k++) begin rx_v[k] = 0; tx_v[k] = 0; end
    tx_pkt_valid = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] held;
    for (int k = 0; k < NF; k++) begin rx_v[k] = 0; tx_v[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;

    // R1: everything zero after reset
    for (int a = 0; a <= 2*NC+2; a++) rd_abs(a, '0, "R1 reset value");

    // R2: program the bank and read back
    wr(0, 48'h210);               // flit 0, receive, enabled
    wr(1, 48'h310);               // flit 0, transmit, enabled
    wr(2, 48'h232);               // regulator hot
    wr(3, 48'h720);               // packet match, transmit, enabled, reset bit
    wr(2*NC, 48'hF0);             // mask message class only
    wr(2*NC+1, 48'h30);           // match class 3
    rd_abs(3, 48'h320, "R2 control readback, R10 reset bit reads 0");
    rd_abs(2*NC, 48'hF0, "R2 mask readback");
    rd_abs(2*NC+1, 48'h30, "R2 match readback");

    // R3 R4 R5 R6: mixed traffic
    traffic = 1;
    repeat (80) @(negedge clk);
    quiet();
    rd_chk(NC+0, "R3 receive flit count");
    rd_chk(NC+1, "R4 transmit flit count, other direction ignored");
    rd_chk(NC+2, "R5 regulator hot count");
    rd_chk(NC+3, "R6 mask/match packet count");

    // R6: packet event with receive direction adds nothing
    wr(3, 48'h620);
    traffic = 1;
    repeat (30) @(negedge clk);
    quiet();
    rd_abs(NC+3, '0, "R6 receive direction adds nothing");

    // R7: unsupported code
    wr(0, 48'h655);
    traffic = 1;
    repeat (30) @(negedge clk);
    quiet();
    rd_abs(NC+0, '0, "R7 unsupported code");

    // R8: disabled counter holds
    wr(1, 48'h110);
    @(negedge clk); reg_addr = AW'(NC+1); #1; held = reg_rdata;
    traffic = 1;
    repeat (30) @(negedge clk);
    quiet();
    rd_abs(NC+1, held, "R8 disabled counter holds");
    rd_chk(NC+1, "R8 disabled counter vs model");

    // R9: write beats same-cycle increment (regulator hot held high)
    vr_hot = 1'b1;
    wr(2, 48'h232);
    wr(NC+2, 48'd1000);
    rd_chk(NC+2, "R9 write wins");
    rd_abs(NC+2, 48'd1002, "R9 write then two increments");

    // R10: reset bit clears
    wr(2, 48'h632);
    rd_abs(NC+2, 48'd1, "R10 reset bit clears, then one increment");

    // R11: wrap and flag
    wr(NC+2, TOP - 48'd2);
    repeat (3) @(negedge clk);
    rd_chk(NC+2, "R11 wrapped value");
    rd_abs(2*NC+2, 48'h4, "R11 overflow flag set");

    // R12: clear, then clear on the same edge as a carry
    wr(2*NC+2, 48'h4);
    rd_abs(2*NC+2, 48'h0, "R12 write-one clears flag");
    wr(NC+2, TOP - 48'd1);
    wr(2*NC+2, 48'h4);
    rd_abs(2*NC+2, 48'h4, "R12 set wins over same-cycle clear");
    rd_chk(NC+2, "R12 counter after wrap");

    vr_hot = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule